// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register Block

This block is the software-facing command register of a per-core interrupt controller. Software writes a 64-bit interrupt command as two 32-bit words on a simple register bus. The upper word stages the target core, and the lower word carries the vector, the delivery mode and the level. Only the store to the lower word turns the command into an outbound message. A store to the upper word only changes the staged target.

The outbound message leaves on a valid/ready port. A read-only delivery-status bit in the lower word tells software that a message is still waiting for the fabric to accept it. While that bit is set, further stores to the lower word are discarded. The local core's identifier can be read from its own register. Reserved command bits keep their values across any write, and any write narrower than a full word is ignored.

Top module: `ipi_cmd_regs`

## Requirements
- R1: After reset, both command words read zero, `msg_valid` is low, and the core-ID register at offset 0x020 holds `core_id_i` in bits 31:24 and zero in all other bits.
- R2: Offset 0x310 is the upper command word. A full write updates only bits 31:24, which hold the destination core ID. That write never raises `msg_valid`.
- R3: Offset 0x300 is the lower command word. A full write while idle raises `msg_valid` on the next cycle. The message carries the vector from bits 7:0, the mode from bits 10:8, the level from bit 14, and the destination currently held in the upper word.
- R4: Reserved command bits are bits 13, 17:16 and 31:20 of the lower word and bits 23:0 of the upper word. Writes never change them, and reads return their held reset value of zero.
- R5: A write with `bus_be` other than 4'hF changes no register and launches nothing.
- R6: Bit 12 of the lower word reads 1 from the launch until the cycle after `msg_valid && msg_ready`, and reads 0 otherwise. A write cannot set or clear it.
- R7: A write to the lower word while bit 12 is set is discarded. No second message is sent, and the lower word keeps its contents.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_dest`, `msg_mode`, `msg_vector` and `msg_level` hold steady, even if the upper word is rewritten.
- R9: Writing 0x0000_4400 to the lower word sends mode 3'b100 (non-maskable) with level 1 and vector 0.
- R10: Reads from any offset other than 0x020, 0x300 and 0x310 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| core_id_i | input | 8 | Identifier of the local core |
| msg_valid | output | 1 | Outbound message pending |
| msg_ready | input | 1 | Fabric accepts the message |
| msg_dest | output | 8 | Destination core ID |
| msg_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Interrupt vector |
| msg_level | output | 1 | Level (1 = assert) |

## Verification
The bench sweeps vectors, modes, levels and destinations with every reserved bit set in the write data. A design that leaks reserved or status bits into storage shows up on readback, and a design that mixes up field positions shows up on the message port. It rewrites the upper word while a message is stalled, which catches a design that routes the live register to the port instead of a latched copy. It also hits the lower word again while busy, which catches a design that relaunches or overwrites. Narrow writes and writes that touch only the upper word are checked for having no effect, because a block that decodes the strobe carelessly would send spurious messages.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int ID_W   = 8;
    localparam int VEC_W  = 8;
    localparam int MODE_W = 3;

    localparam logic [ADDR_W-1:0] OFS_CORE_ID = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_CMD_LO  = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_CMD_HI  = 12'h310;

    localparam int VEC_LSB    = 0;
    localparam int MODE_LSB   = 8;
    localparam int STATUS_BIT = 12;
    localparam int LEVEL_BIT  = 14;
    localparam int DEST_LSB   = DATA_W - ID_W;

    localparam logic [DATA_W-1:0] LO_RSVD   = 32'hFFF3_2000;
    localparam logic [DATA_W-1:0] LO_STATUS = 32'h0000_1000;
    localparam logic [DATA_W-1:0] LO_WMASK  = ~(LO_RSVD | LO_STATUS);
    localparam logic [DATA_W-1:0] HI_WMASK  = {{ID_W{1'b1}}, {(DATA_W-ID_W){1'b0}}};

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ID,
        SEL_LO,
        SEL_HI
    } reg_sel_e;

    typedef struct packed {
        logic [ID_W-1:0]   dest;
        logic [MODE_W-1:0] mode;
        logic              level;
        logic [VEC_W-1:0]  vector;
    } ipi_msg_t;

    function automatic logic [DATA_W-1:0] merge_masked(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [DATA_W-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    function automatic ipi_msg_t build_msg(
        input logic [DATA_W-1:0] lo,
        input logic [DATA_W-1:0] hi
    );
        ipi_msg_t m;
        m.dest   = hi[DEST_LSB +: ID_W];
        m.mode   = lo[MODE_LSB +: MODE_W];
        m.level  = lo[LEVEL_BIT];
        m.vector = lo[VEC_LSB +: VEC_W];
        return m;
    endfunction
endpackage

// File: rtl/ipi_reg_decode.sv
module ipi_reg_decode
    import ipi_cmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BE_W-1:0]   be,
    output reg_sel_e          sel,
    output logic              wr_lo,
    output logic              wr_hi
);
    logic full_wr;

    always_comb begin
        unique case (addr)
            OFS_CORE_ID: sel = SEL_ID;
            OFS_CMD_LO:  sel = SEL_LO;
            OFS_CMD_HI:  sel = SEL_HI;
            default:     sel = SEL_NONE;
        endcase
    end

    assign full_wr = we && (be == {BE_W{1'b1}});
    assign wr_lo   = full_wr && (sel == SEL_LO);
    assign wr_hi   = full_wr && (sel == SEL_HI);
endmodule

// File: rtl/ipi_cmd_store.sv
module ipi_cmd_store
    import ipi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lo_q,
    output logic [DATA_W-1:0] hi_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= merge_masked(lo_q, wdata, LO_WMASK);
            if (wr_hi) hi_q <= merge_masked(hi_q, wdata, HI_WMASK);
        end
    end
endmodule

// File: rtl/ipi_msg_launch.sv
module ipi_msg_launch
    import ipi_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     launch,
    input  ipi_msg_t msg_in,
    input  logic     ready,
    output logic     busy,
    output ipi_msg_t msg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            msg_q <= '0;
        end else if (launch && !busy) begin
            busy  <= 1'b1;
            msg_q <= msg_in;
        end else if (busy && ready) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
    import ipi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [ID_W-1:0]   core_id_i,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [ID_W-1:0]   msg_dest,
    output logic [MODE_W-1:0] msg_mode,
    output logic [VEC_W-1:0]  msg_vector,
    output logic              msg_level
);
    reg_sel_e          sel;
    logic              wr_lo, wr_hi, wr_lo_ok, busy;
    logic [DATA_W-1:0] lo_q, hi_q;
    ipi_msg_t          next_msg, msg_q;

    ipi_reg_decode dec_i (
        .addr(bus_addr), .we(bus_we), .be(bus_be),
        .sel(sel), .wr_lo(wr_lo), .wr_hi(wr_hi)
    );

    assign wr_lo_ok = wr_lo && !busy;

    ipi_cmd_store store_i (
        .clk(clk), .rst(rst), .wr_lo(wr_lo_ok), .wr_hi(wr_hi),
        .wdata(bus_wdata), .lo_q(lo_q), .hi_q(hi_q)
    );

    assign next_msg = build_msg(merge_masked(lo_q, bus_wdata, LO_WMASK), hi_q);

    ipi_msg_launch launch_i (
        .clk(clk), .rst(rst), .launch(wr_lo_ok), .msg_in(next_msg),
        .ready(msg_ready), .busy(busy), .msg_q(msg_q)
    );

    always_comb begin
        unique case (sel)
            SEL_ID:  bus_rdata = {core_id_i, {(DATA_W-ID_W){1'b0}}};
            SEL_LO:  bus_rdata = (lo_q & ~LO_STATUS) | (DATA_W'(busy) << STATUS_BIT);
            SEL_HI:  bus_rdata = hi_q;
            default: bus_rdata = '0;
        endcase
    end

    assign msg_valid  = busy;
    assign msg_dest   = msg_q.dest;
    assign msg_mode   = msg_q.mode;
    assign msg_vector = msg_q.vector;
    assign msg_level  = msg_q.level;
endmodule

// File: rtl/ipi_cmd_regs_chk.sv
module ipi_cmd_regs_chk
    import ipi_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BE_W-1:0]   bus_be,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [ID_W-1:0]   msg_dest,
    input logic [MODE_W-1:0] msg_mode,
    input logic [VEC_W-1:0]  msg_vector,
    input logic              msg_level
);
    a_r8_payload_stable: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) && $stable(msg_mode)
                                       && $stable(msg_vector) && $stable(msg_level)));

    a_r2_high_no_launch: assert property (@(posedge clk) disable iff (rst)
        (!msg_valid && bus_we && bus_addr == OFS_CMD_HI) |=> !msg_valid);

    a_r3_low_launches: assert property (@(posedge clk) disable iff (rst)
        (!msg_valid && bus_we && bus_be == 4'hF && bus_addr == OFS_CMD_LO) |=> msg_valid);

    a_r5_partial_ignored: assert property (@(posedge clk) disable iff (rst)
        (!msg_valid && bus_we && bus_be != 4'hF && bus_addr == OFS_CMD_LO) |=> !msg_valid);

    a_r6_handshake_clears: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready) |=> !msg_valid);
endmodule

bind ipi_cmd_regs ipi_cmd_regs_chk chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_mode(msg_mode), .msg_vector(msg_vector), .msg_level(msg_level)
);

// File: tb/ipi_cmd_regs_tb_top.sv
module ipi_cmd_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  core_id_i = 8'hA7;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_dest, msg_vector;
    logic [2:0]  msg_mode;
    logic        msg_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] LO_KEEP = 32'h000C_CFFF;
    localparam logic [31:0] HI_KEEP = 32'hFF00_0000;

    always #2 clk = ~clk;

    ipi_cmd_regs dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_id_i(core_id_i),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
        .msg_mode(msg_mode), .msg_vector(msg_vector), .msg_level(msg_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic handshake();
        @(negedge clk);
        msg_ready = 1'b1;
        @(posedge clk);
        #1 msg_ready = 1'b0;
    endtask

    initial begin
        logic [31:0] r, data;
        logic [7:0]  dst;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(12'h300, r); check("R1 lo", r, 32'h0);
        rd(12'h310, r); check("R1 hi", r, 32'h0);
        check("R1 valid", {31'b0, msg_valid}, 32'h0);
        rd(12'h020, r); check("R1 core id", r, 32'hA700_0000);
        // R10 unmapped
        rd(12'h024, r); check("R10 unmapped", r, 32'h0);
        rd(12'h304, r); check("R10 unmapped", r, 32'h0);

        // R2 high write stages only; reserved bits stay (R4)
        wr(12'h310, 32'hFFFF_FFFF, 4'hF);
        @(negedge clk); check("R2 no launch", {31'b0, msg_valid}, 32'h0);
        rd(12'h310, r); check("R4 hi rsvd", r, 32'hFF00_0000);

        // R5 partial writes ignored
        wr(12'h300, 32'h0000_44FF, 4'h3);
        @(negedge clk); check("R5 no launch", {31'b0, msg_valid}, 32'h0);
        rd(12'h300, r); check("R5 lo unchanged", r, 32'h0);
        wr(12'h310, 32'h1200_0000, 4'h8);
        rd(12'h310, r); check("R5 hi unchanged", r, 32'hFF00_0000);

        // R9 NMI command word
        wr(12'h310, 32'h3C00_0000, 4'hF);
        wr(12'h300, 32'h0000_4400, 4'hF);
        @(negedge clk);
        check("R9 valid", {31'b0, msg_valid}, 32'h1);
        check("R9 mode", {29'b0, msg_mode}, 32'h4);
        check("R9 level", {31'b0, msg_level}, 32'h1);
        check("R9 vector", {24'b0, msg_vector}, 32'h0);
        check("R9 dest", {24'b0, msg_dest}, 32'h3C);
        handshake();
        @(negedge clk); check("R6 cleared", {31'b0, msg_valid}, 32'h0);

        // Sweep: vector, mode, level, dest, with all reserved bits set
        for (int i = 0; i < 256; i++) begin
            dst  = 8'(i) ^ 8'h5A;
            data = 32'hFFF3_3000 | 32'(i) | (32'(i % 8) << 8) | (32'(i & 1) << 14)
                   | (32'((i >> 1) & 1) << 11) | (32'((i >> 2) & 1) << 15)
                   | (32'((i >> 3) & 3) << 18);
            wr(12'h310, {dst, 24'hFFFFFF}, 4'hF);
            wr(12'h300, data, 4'hF);
            @(negedge clk);
            check("R3 valid", {31'b0, msg_valid}, 32'h1);
            check("R3 vector", {24'b0, msg_vector}, 32'(i & 255));
            check("R3 mode", {29'b0, msg_mode}, 32'(i % 8));
            check("R3 level", {31'b0, msg_level}, 32'(i & 1));
            check("R3 dest", {24'b0, msg_dest}, {24'b0, dst});
            rd(12'h300, r);
            check("R4 R6 lo readback", r, (data & LO_KEEP) | 32'h0000_1000);
            // R8: stall a few cycles and rewrite the upper word
            wr(12'h310, {~dst, 24'h0}, 4'hF);
            for (int k = 0; k < (i % 3); k++) @(posedge clk);
            @(negedge clk);
            check("R8 dest held", {24'b0, msg_dest}, {24'b0, dst});
            check("R8 vector held", {24'b0, msg_vector}, 32'(i & 255));
            // R7: a second low write while busy is discarded
            if (i % 4 == 0) begin
                wr(12'h300, 32'h0000_0000, 4'hF);
                rd(12'h300, r);
                check("R7 lo kept", r, (data & LO_KEEP) | 32'h0000_1000);
                check("R7 vector kept", {24'b0, msg_vector}, 32'(i & 255));
            end
            handshake();
            @(negedge clk);
            check("R6 done", {31'b0, msg_valid}, 32'h0);
            rd(12'h300, r);
            check("R6 status low", r, data & LO_KEEP);
            if (i % 4 == 0) begin
                @(negedge clk);
                check("R7 no second msg", {31'b0, msg_valid}, 32'h0);
            end
        end

        // R6: writing bit 12 alone does not set status beyond a launch
        wr(12'h300, 32'h0000_1000, 4'h7);
        rd(12'h300, r);
        check("R6 partial no status", r[12] ? 32'h1 : 32'h0, 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule